// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

The block gathers status-change events from four groups of event inputs. A rising or a falling transition on any event input sets a sticky bit in that group's status register. Each group also has an enable register, and the host interrupt request is asserted while at least one set status bit has its enable bit set. The host finds the cause by reading the status registers.

A global control register sets two things. The first is how status is cleared: either a read clears the whole group, or the host writes ones to clear individual bits. The second is how the interrupt pin is driven: either as an open-drain wired-OR line that only pulls low, or as a pin driven high whenever no interrupt is pending. The pin is modelled as a value (`irq_o`) and an output enable (`irq_oe_o`), so a pad or an external pull-up can be attached outside the block.

The register port is a single address bus with one-cycle read and write strobes. The word map is as follows. Status of group g is at address g. Enable of group g is at address NUM_GRP+g. Control is at address 2*NUM_GRP. Read data is registered.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all status, enable and control bits are 0, `rd_data_o` is 0 and the pin is released (`irq_oe_o`=0, `irq_o`=0).
- R2: A rising or a falling transition on event input bit b of group g (`event_i[g*GRP_W+b]`) sets status bit b of group g. The bit is set on the third rising clock edge after the input changes.
- R3: A status bit latches even when its enable bit is 0, but it does not assert the interrupt.
- R4: When the drive-high bit (control bit 1) is 0 and any status bit is set together with its enable bit, the block drives the pin low (`irq_oe_o`=1, `irq_o`=0). Otherwise it releases the pin (`irq_oe_o`=0).
- R5: When the clear-on-write bit (control bit 0) is 0, a read at address g returns that group's status one cycle after the strobe and clears the whole group. Other groups are unaffected.
- R6: When control bit 0 is 1, reads leave status unchanged. A write to address g clears exactly the status bits written as 1.
- R7: When control bit 0 is 0, a write to a status address has no effect.
- R8: An event that lands in the same cycle as a clearing read or write remains set afterwards.
- R9: When control bit 1 is 1, `irq_oe_o` is always 1 and `irq_o` is 0 while the interrupt is asserted and 1 otherwise.
- R10: Enable registers (addresses NUM_GRP..2*NUM_GRP-1) and the control register (address 2*NUM_GRP, bits 1:0) are written by the write strobe and read back unchanged.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_GRP*GRP_W | Asynchronous event inputs, group g in bits g*GRP_W upward |
| rd_en_i | input | 1 | Read strobe, one cycle |
| wr_en_i | input | 1 | Write strobe, one cycle |
| addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | GRP_W | Write data |
| rd_data_o | output | GRP_W | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt pin value, low means active |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that read and write strobes never occur in the same cycle. They also assume that the control register changes only through a write, so a cycle with no write strobe keeps the clear mode fixed. The stimulus issues one strobe at a time, and it toggles event inputs only at falling clock edges. The same-cycle cases are timed so that the synchronized edge meets the clearing strobe on exactly the same rising edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic drive_high;  // bit 1
    logic cow;         // bit 0
  } irq_ctrl_t;

  localparam int CTRL_W = $bits(irq_ctrl_t);
endpackage

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] edge_o
);
  logic [STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= '0;
    end else begin
      sync_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  // any transition counts
  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/irq_status_grp.sv
module irq_status_grp #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q;

  // set wins over clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  parameter int STAGES  = 2,
  parameter int ADDR_W  = $clog2(2*NUM_GRP+1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] event_i,
  input  logic                     rd_en_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [GRP_W-1:0]         wr_data_i,
  output logic [GRP_W-1:0]         rd_data_o,
  output logic                     irq_o,
  output logic                     irq_oe_o
);
  localparam int EN_BASE   = NUM_GRP;
  localparam int CTRL_ADDR = 2*NUM_GRP;

  logic [NUM_GRP-1:0][GRP_W-1:0] status_q;
  logic [NUM_GRP-1:0][GRP_W-1:0] enable_q;
  logic [NUM_GRP-1:0][GRP_W-1:0] edge_pulse;
  logic [NUM_GRP-1:0][GRP_W-1:0] clr_vec;
  logic [NUM_GRP-1:0]            grp_pend;
  irq_ctrl_t                     ctrl_q;
  logic [GRP_W-1:0]              rd_mux;
  logic [GRP_W-1:0]              rd_data_q;
  logic                          irq_active;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic st_rd, st_wr, en_wr;
    assign st_rd = rd_en_i && (addr_i == ADDR_W'(g));
    assign st_wr = wr_en_i && (addr_i == ADDR_W'(g));
    assign en_wr = wr_en_i && (addr_i == ADDR_W'(EN_BASE + g));

    irq_event_detect #(.W(GRP_W), .STAGES(STAGES)) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (event_i[g*GRP_W +: GRP_W]),
      .edge_o  (edge_pulse[g])
    );

    always_comb begin
      clr_vec[g] = '0;
      if (!ctrl_q.cow && st_rd)     clr_vec[g] = '1;
      else if (ctrl_q.cow && st_wr) clr_vec[g] = wr_data_i;
    end

    irq_status_grp #(.W(GRP_W)) u_st (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (edge_pulse[g]),
      .clr_i    (clr_vec[g]),
      .status_o (status_q[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    enable_q[g] <= '0;
      else if (en_wr) enable_q[g] <= wr_data_i;
    end

    assign grp_pend[g] = |(status_q[g] & enable_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(CTRL_ADDR))
      ctrl_q <= irq_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr_i == ADDR_W'(g))           rd_mux = status_q[g];
      if (addr_i == ADDR_W'(EN_BASE + g)) rd_mux = enable_q[g];
    end
    if (addr_i == ADDR_W'(CTRL_ADDR))
      rd_mux = {{(GRP_W-CTRL_W){1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_mux;
  end

  assign rd_data_o  = rd_data_q;
  assign irq_active = |grp_pend;

  // open-drain: pull low only; driven mode: always enabled, high when idle
  assign irq_oe_o = ctrl_q.drive_high | irq_active;
  assign irq_o    = ctrl_q.drive_high & ~irq_active;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  parameter int ADDR_W  = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rd_en_i,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [GRP_W-1:0]              rd_data_o,
  input logic                          irq_o,
  input logic                          irq_oe_o,
  input logic [NUM_GRP-1:0][GRP_W-1:0] status_i,
  input logic [NUM_GRP-1:0][GRP_W-1:0] enable_i,
  input logic [NUM_GRP-1:0][GRP_W-1:0] edge_i,
  input logic                          cow_i,
  input logic                          dh_i
);
  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |edge_i |=> ((status_i & $past(edge_i)) == $past(edge_i)));

  p_od_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dh_i && ((status_i & enable_i) == '0)) |-> !irq_oe_o);

  p_od_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dh_i && irq_oe_o) |-> !irq_o);

  p_cow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cow_i && !wr_en_i) |=> ((status_i & $past(status_i)) == $past(status_i)));

  p_dh_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dh_i |-> irq_oe_o);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    p_rdata_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADDR_W'(g)) |=> (rd_data_o == $past(status_i[g])));

    p_cor_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !cow_i && addr_i == ADDR_W'(g))
        |=> ((status_i[g] & ~$past(edge_i[g])) == '0));

    p_keep_new_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rd_en_i || wr_en_i) && addr_i == ADDR_W'(g) && |edge_i[g])
        |=> ((status_i[g] & $past(edge_i[g])) == $past(edge_i[g])));
  end
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .NUM_GRP (NUM_GRP),
  .GRP_W   (GRP_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .irq_oe_o  (irq_oe_o),
  .status_i  (status_q),
  .enable_i  (enable_q),
  .edge_i    (edge_pulse),
  .cow_i     (ctrl_q.cow),
  .dh_i      (ctrl_q.drive_high)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  localparam int NUM_GRP = 4;
  localparam int GRP_W   = 8;
  localparam int ADDR_W  = 4;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [NUM_GRP*GRP_W-1:0] ev = '0;
  logic                     rd_en = 1'b0;
  logic                     wr_en = 1'b0;
  logic [ADDR_W-1:0]        addr = '0;
  logic [GRP_W-1:0]         wdata = '0;
  logic [GRP_W-1:0]         rdata;
  logic                     irq, irq_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [GRP_W-1:0] exp_q[$];
  string            tag_q[$];

  always #2 clk = ~clk;

  irq_status_ctrl #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .event_i   (ev),
    .rd_en_i   (rd_en),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq),
    .irq_oe_o  (irq_oe)
  );

  // monitor: pops expected read data the cycle after each strobe
  initial begin
    forever begin
      bit pend;
      @(posedge clk);
      pend = rd_en;
      @(negedge clk);
      if (pend) begin
        logic [GRP_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s: rd_data actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = GRP_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    exp_q.push_back(GRP_W'(e)); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tog(input int g, input int b);
    @(negedge clk);
    ev[g*GRP_W+b] = ~ev[g*GRP_W+b];
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_pin(input logic oe_e, input logic o_e, input string t);
    @(negedge clk);
    total++;
    if (irq_oe !== oe_e || irq !== o_e) begin
      bad++;
      $display("FAIL %s: oe/o actual=%b/%b expected=%b/%b", t, irq_oe, irq, oe_e, o_e);
    end
  endtask

  initial begin
    #80000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_pin(1'b0, 1'b0, "R1");
    for (int a = 0; a <= 8; a++) rd(a, 0, "R1");
    // R10 register map
    wr(4, 8'h0F); wr(5, 8'hF0); wr(6, 8'hFF); wr(7, 8'h01);
    rd(4, 8'h0F, "R10"); rd(5, 8'hF0, "R10"); rd(6, 8'hFF, "R10"); rd(7, 8'h01, "R10");
    // R2/R3 rising and falling edges, disabled bit
    tog(3, 4);
    chk_pin(1'b0, 1'b0, "R3");
    rd(3, 8'h10, "R2");
    rd(3, 8'h00, "R5");
    tog(3, 4);
    rd(3, 8'h10, "R2");
    // R4 enabled event drives low; R5 per-group clear
    tog(0, 1);
    tog(1, 0);
    chk_pin(1'b1, 1'b0, "R4");
    rd(1, 8'h01, "R3");
    chk_pin(1'b1, 1'b0, "R5");
    rd(0, 8'h02, "R5");
    chk_pin(1'b0, 1'b0, "R5");
    // R11 unmapped
    wr(15, 8'hFF); wr(9, 8'hFF);
    rd(15, 0, "R11"); rd(9, 0, "R11"); rd(8, 0, "R11");
    // R7 write ignored in clear-on-read mode
    tog(0, 2);
    wr(0, 8'hFF);
    chk_pin(1'b1, 1'b0, "R7");
    rd(0, 8'h04, "R7");
    chk_pin(1'b0, 1'b0, "R7");
    // R6 clear-on-write mode
    wr(8, 1);
    rd(8, 1, "R10");
    tog(2, 0);
    tog(2, 5);
    rd(2, 8'h21, "R6");
    rd(2, 8'h21, "R6");
    wr(2, 8'h01);
    rd(2, 8'h20, "R6");
    chk_pin(1'b1, 1'b0, "R6");
    wr(2, 8'h20);
    rd(2, 8'h00, "R6");
    chk_pin(1'b0, 1'b0, "R6");
    // R8 event coincident with clearing write
    @(negedge clk); ev[2*GRP_W+6] = ~ev[2*GRP_W+6];
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2; wdata = 8'hFF;
    @(negedge clk); wr_en = 1'b0;
    rd(2, 8'h40, "R8");
    wr(2, 8'h40);
    // R8 event coincident with clearing read
    wr(8, 0);
    @(negedge clk); ev[1*GRP_W+7] = ~ev[1*GRP_W+7];
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 1;
    exp_q.push_back(8'h00); tag_q.push_back("R8");
    @(negedge clk); rd_en = 1'b0;
    chk_pin(1'b1, 1'b0, "R8");
    rd(1, 8'h80, "R8");
    chk_pin(1'b0, 1'b0, "R8");
    // R9 driven-high mode
    wr(8, 2);
    rd(8, 2, "R10");
    chk_pin(1'b1, 1'b1, "R9");
    tog(0, 0);
    chk_pin(1'b1, 1'b0, "R9");
    rd(0, 8'h01, "R9");
    chk_pin(1'b1, 1'b1, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule